// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block sits beside a small processor core and decides which interrupt the core should take next. It holds a sticky pending flag for each of up to 96 request lines. Each flag passes through a per-source enable and then feeds one of up to 63 vectors. Every vector carries a programmable group priority (3 bits) and a sub-priority (2 bits). The arbiter picks one winning vector. The higher group wins first. Within a group the higher sub-priority wins. When both are equal, the lower vector number wins.

The block raises its request line only when the winner's group priority is strictly above the level the core is running at. When the core acknowledges, that group becomes the running level, and the previous level is saved on an internal stack. A return strobe restores the saved level. A mode bit selects between reporting the real vector number and reporting vector 0 for every request. All configuration goes through a word-wide register write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request line is low, the reported vector is 0, the running level is 0, every flag and enable is clear, every vector has group and sub-priority 0, and the single-vector mode is active.
- R2: A pulse on a request line sets its flag, and the flag stays set until software clears it. A write to address 0x10+w clears the flags of sources 32w+b for each set data bit b. If a new request and a clear for the same source arrive in the same cycle, the flag stays set.
- R3: A write to address 0x20+w loads the enables of sources 32w to 32w+31 from the data bits. A flag whose enable is 0 takes no part in arbitration, but it is still kept.
- R4: Source s feeds vector s mod 63. A vector is pending when any of its enabled sources has a set flag.
- R5: A write to address 0x40+v sets vector v's group priority from data bits [4:2] and its sub-priority from bits [1:0]. A vector with group priority 0 never wins and never raises a request.
- R6: Among pending vectors the highest group priority wins. A tie in group is broken by the highest sub-priority. A full tie is broken by the lowest vector number.
- R7: The request line is high only while the winner's group priority is strictly greater than the running level. A winner whose group equals the running level raises no request, whatever its sub-priority.
- R8: An acknowledge taken while the request line is high makes the winner's group the running level and pushes the old level onto the stack. The request line is low in the following cycle.
- R9: A return strobe, when no acknowledge is taken in the same cycle, pops the saved level back into the running level. A return on an empty stack sets the running level to 0.
- R10: Bit 0 of address 0x00 selects the mode: 1 reports the winning vector number, and 0 reports vector 0 for every request. In both modes priority still decides whether a request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | NUM_SRC | Interrupt request pulses, one per source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration write address |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| irq_ack_i | input | 1 | Core acknowledges the presented request |
| irq_ret_i | input | 1 | Core returns from the current handler |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | clog2(NUM_VEC) | Vector number presented with the request |
| cur_pri_o | output | 3 | Current running priority level |

## Verification
Three kinds of stimulus take effect after one clock edge: a request pulse, a priority or enable write, and a clear write. Each updates its state at that edge, and the request line and vector follow at the second edge. An acknowledge or return changes the running level at its own edge, and the request line is re-evaluated against the new level one edge later. Every driver step therefore drives for exactly one edge, then waits one more falling edge before it queues its expected request, vector and level. The monitor compares those values at that falling edge, well away from any update.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int GRP_W = 3;
  localparam int SUB_W = 2;
  localparam int KEY_W = GRP_W + SUB_W;
  typedef logic [GRP_W-1:0] grp_t;
  typedef logic [SUB_W-1:0] sub_t;
endpackage

// File: rtl/pic_src_bank.sv
module pic_src_bank #(
  parameter int NUM_SRC = 96,
  parameter int NUM_VEC = 63,
  parameter int DATA_W  = 32,
  parameter int WSEL_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic               clr_we_i,
  input  logic               en_we_i,
  input  logic [WSEL_W-1:0]  wsel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_VEC-1:0] vec_pend_o
);
  logic [NUM_SRC-1:0] flag_q, flag_d;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic [NUM_SRC-1:0] live;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int WORD = s / DATA_W;
    localparam int BITP = s % DATA_W;
    logic word_hit;
    assign word_hit = (wsel_i == WSEL_W'(WORD));
    // new request wins over a simultaneous clear
    assign flag_d[s] = (flag_q[s] & ~(clr_we_i & word_hit & wdata_i[BITP])) | src_req_i[s];
    assign en_d[s]   = (en_we_i & word_hit) ? wdata_i[BITP] : en_q[s];
    assign live[s]   = flag_q[s] & en_q[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  // fold sources onto vectors: source s drives vector s mod NUM_VEC
  always_comb begin
    vec_pend_o = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      vec_pend_o[s % NUM_VEC] = vec_pend_o[s % NUM_VEC] | live[s];
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int NUM_VEC = 63,
  parameter int VEC_W   = 6
) (
  input  logic [NUM_VEC-1:0]            pend_i,
  input  logic [NUM_VEC-1:0][GRP_W-1:0] grp_i,
  input  logic [NUM_VEC-1:0][SUB_W-1:0] sub_i,
  output logic                          valid_o,
  output logic [VEC_W-1:0]              vec_o,
  output grp_t                          grp_o
);
  logic [KEY_W-1:0] best_key;
  logic [VEC_W-1:0] best_vec;
  logic             best_ok;

  // scan from the top index down; ">=" lets a lower index take a full tie
  always_comb begin
    best_key = '0;
    best_vec = '0;
    best_ok  = 1'b0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (pend_i[v] && (grp_i[v] != '0) && ({grp_i[v], sub_i[v]} >= best_key)) begin
        best_key = {grp_i[v], sub_i[v]};
        best_vec = VEC_W'(v);
        best_ok  = 1'b1;
      end
    end
  end

  assign valid_o = best_ok;
  assign vec_o   = best_vec;
  assign grp_o   = best_key[KEY_W-1:SUB_W];
endmodule

// File: rtl/pic_lvl_stack.sv
module pic_lvl_stack
  import pic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic pop_i,
  input  grp_t push_lvl_i,
  output grp_t cur_lvl_o,
  output logic empty_o
);
  // levels only rise on push, so one slot per nonzero level suffices
  localparam int DEPTH = (1 << GRP_W) - 1;
  localparam int PTR_W = $clog2(DEPTH + 1);

  grp_t             mem_q [DEPTH];
  grp_t             cur_q, cur_d;
  logic [PTR_W-1:0] sp_q, sp_d;
  logic             wr_en;

  always_comb begin
    cur_d = cur_q;
    sp_d  = sp_q;
    wr_en = 1'b0;
    if (push_i) begin
      cur_d = push_lvl_i;
      if (sp_q < PTR_W'(DEPTH)) begin
        wr_en = 1'b1;
        sp_d  = sp_q + 1'b1;
      end
    end else if (pop_i) begin
      if (sp_q != '0) begin
        cur_d = mem_q[sp_q - 1'b1];
        sp_d  = sp_q - 1'b1;
      end else begin
        cur_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      sp_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cur_q <= cur_d;
      sp_q  <= sp_d;
      if (wr_en) mem_q[sp_q] <= cur_q;
    end
  end

  assign cur_lvl_o = cur_q;
  assign empty_o   = (sp_q == '0);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int NUM_VEC = 63,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         src_req_i,
  input  logic                       cfg_we_i,
  input  logic [ADDR_W-1:0]          cfg_addr_i,
  input  logic [DATA_W-1:0]          cfg_wdata_i,
  input  logic                       irq_ack_i,
  input  logic                       irq_ret_i,
  output logic                       irq_o,
  output logic [$clog2(NUM_VEC)-1:0] irq_vec_o,
  output logic [GRP_W-1:0]           cur_pri_o
);
  localparam int VEC_W    = $clog2(NUM_VEC);
  localparam int NW       = (NUM_SRC + DATA_W - 1) / DATA_W;
  localparam int WSEL_W   = (NW > 1) ? $clog2(NW) : 1;
  localparam int CTRL_ADR = 'h00;
  localparam int CLR_BASE = 'h10;
  localparam int EN_BASE  = 'h20;
  localparam int PRI_BASE = 'h40;

  // ---------------- address decode ----------------
  logic              ctrl_we, clr_we, en_we, pri_we;
  logic [WSEL_W-1:0] wsel;
  logic [ADDR_W-1:0] pri_idx;

  always_comb begin
    ctrl_we = cfg_we_i && (cfg_addr_i == ADDR_W'(CTRL_ADR));
    clr_we  = cfg_we_i && (cfg_addr_i >= ADDR_W'(CLR_BASE)) && (cfg_addr_i < ADDR_W'(CLR_BASE + NW));
    en_we   = cfg_we_i && (cfg_addr_i >= ADDR_W'(EN_BASE))  && (cfg_addr_i < ADDR_W'(EN_BASE + NW));
    pri_we  = cfg_we_i && (cfg_addr_i >= ADDR_W'(PRI_BASE)) && (cfg_addr_i < ADDR_W'(PRI_BASE + NUM_VEC));
    pri_idx = cfg_addr_i - ADDR_W'(PRI_BASE);
    wsel    = clr_we ? WSEL_W'(cfg_addr_i - ADDR_W'(CLR_BASE)) : WSEL_W'(cfg_addr_i - ADDR_W'(EN_BASE));
  end

  // ---------------- configuration registers ----------------
  logic                          multi_q, multi_d;
  logic [NUM_VEC-1:0][GRP_W-1:0] grp_q, grp_d;
  logic [NUM_VEC-1:0][SUB_W-1:0] sub_q, sub_d;

  assign multi_d = ctrl_we ? cfg_wdata_i[0] : multi_q;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vcfg
    logic hit;
    assign hit      = pri_we && (pri_idx == ADDR_W'(v));
    assign grp_d[v] = hit ? cfg_wdata_i[KEY_W-1:SUB_W] : grp_q[v];
    assign sub_d[v] = hit ? cfg_wdata_i[SUB_W-1:0]     : sub_q[v];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      multi_q <= 1'b0;
      grp_q   <= '0;
      sub_q   <= '0;
    end else begin
      multi_q <= multi_d;
      grp_q   <= grp_d;
      sub_q   <= sub_d;
    end
  end

  // ---------------- sources, arbitration, level stack ----------------
  logic [NUM_VEC-1:0] vec_pend;
  logic               arb_valid;
  logic [VEC_W-1:0]   arb_vec;
  grp_t               arb_grp;
  grp_t               cur_lvl;
  logic               stk_empty;

  pic_src_bank #(
    .NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC), .DATA_W(DATA_W), .WSEL_W(WSEL_W)
  ) src_i (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req_i),
    .clr_we_i(clr_we), .en_we_i(en_we), .wsel_i(wsel), .wdata_i(cfg_wdata_i),
    .vec_pend_o(vec_pend)
  );

  pic_arbiter #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) arb_i (
    .pend_i(vec_pend), .grp_i(grp_q), .sub_i(sub_q),
    .valid_o(arb_valid), .vec_o(arb_vec), .grp_o(arb_grp)
  );

  // ---------------- CPU-facing request registers ----------------
  logic             irq_q, irq_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  grp_t             wgrp_q, wgrp_d;
  logic             take;

  assign take   = irq_ack_i && irq_q;
  assign irq_d  = take ? 1'b0 : (arb_valid && (arb_grp > cur_lvl));
  assign vec_d  = multi_q ? arb_vec : '0;
  assign wgrp_d = arb_grp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      wgrp_q <= '0;
    end else begin
      irq_q  <= irq_d;
      vec_q  <= vec_d;
      wgrp_q <= wgrp_d;
    end
  end

  pic_lvl_stack stk_i (
    .clk(clk), .rst_n(rst_n),
    .push_i(take), .pop_i(irq_ret_i && !take), .push_lvl_i(wgrp_q),
    .cur_lvl_o(cur_lvl), .empty_o(stk_empty)
  );

  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;
  assign cur_pri_o = cur_lvl;
endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import pic_pkg::*;
#(
  parameter int VEC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input grp_t             cur_pri_o,
  input logic             irq_ack_i,
  input logic             irq_ret_i,
  input grp_t             wgrp_q,
  input logic             multi_q,
  input logic             stk_empty
);
  assert_req_above_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (wgrp_q > cur_pri_o));

  assert_no_zero_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (wgrp_q != '0));

  assert_ack_takes_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && irq_o) |=> ((cur_pri_o == $past(wgrp_q)) && !irq_o));

  assert_level_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(irq_ack_i && irq_o) && !irq_ret_i) |=> $stable(cur_pri_o));

  assert_ret_empty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret_i && !(irq_ack_i && irq_o) && stk_empty) |=> (cur_pri_o == '0));

  assert_single_vec_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !multi_q |=> (irq_vec_o == '0));
endmodule

bind prio_irq_ctrl pic_checker #(.VEC_W($clog2(NUM_VEC))) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .irq_vec_o(irq_vec_o),
  .cur_pri_o(cur_pri_o), .irq_ack_i(irq_ack_i), .irq_ret_i(irq_ret_i),
  .wgrp_q(wgrp_q), .multi_q(multi_q), .stk_empty(stk_empty)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int NS = 96;
  localparam int NV = 63;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_req;
  logic          cfg_we;
  logic [7:0]    cfg_addr;
  logic [31:0]   cfg_wdata;
  logic          irq_ack, irq_ret;
  logic          irq_o;
  logic [5:0]    irq_vec_o;
  logic [2:0]    cur_pri_o;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NS), .NUM_VEC(NV), .DATA_W(32), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .irq_ack_i(irq_ack),
    .irq_ret_i(irq_ret), .irq_o(irq_o), .irq_vec_o(irq_vec_o), .cur_pri_o(cur_pri_o)
  );

  typedef struct {
    logic       irq;
    logic [5:0] vec;
    logic [2:0] pri;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  event chk_ev;

  // monitor: compares queued expectations at the falling edge
  always begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (irq_o !== e.irq || irq_vec_o !== e.vec || cur_pri_o !== e.pri) begin
        n_fail++;
        $display("FAIL %s: actual irq=%0b vec=%0d pri=%0d expected irq=%0b vec=%0d pri=%0d",
                 e.tag, irq_o, irq_vec_o, cur_pri_o, e.irq, e.vec, e.pri);
      end
    end
  end

  task automatic expect_out(input logic irq, input int vec, input int pri, input string tag);
    exp_t e;
    @(negedge clk);
    e.irq = irq; e.vec = 6'(vec); e.pri = 3'(pri); e.tag = tag;
    exp_q.push_back(e);
    ->chk_ev;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int s);
    src_req[s] = 1'b1;
    @(negedge clk);
    src_req = '0;
  endtask

  task automatic pulse_and_clear(input int s);
    src_req[s] = 1'b1;
    cfg_we = 1'b1; cfg_addr = 8'('h10 + s / 32); cfg_wdata = 32'(1) << (s % 32);
    @(negedge clk);
    src_req = '0; cfg_we = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic ret();
    irq_ret = 1'b1; @(negedge clk); irq_ret = 1'b0;
  endtask

  function automatic logic [31:0] pri_word(input int g, input int s);
    return 32'((g << 2) | s);
  endfunction

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_req = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    irq_ack = 1'b0; irq_ret = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_out(0, 0, 0, "R1 reset state");

    wr('h00, 32'h1);                                // multi-vector mode
    wr('h40 + 5, pri_word(3, 1));
    wr('h40 + 7, pri_word(6, 0));
    wr('h20, 32'h0010_1630);                        // enable 4,5,9,10,12,20
    pulse(5);
    expect_out(1, 5, 0, "R4 R6 single pending vector");

    pulse(7);                                       // source 7 disabled
    expect_out(1, 5, 0, "R3 disabled source ignored");
    wr('h20, 32'h0010_16B0);                        // enable 7 too
    expect_out(1, 7, 0, "R2 R3 flag kept while disabled");
    wr('h10, 32'h80);
    expect_out(1, 5, 0, "R2 software clear");

    pulse_and_clear(5);
    expect_out(1, 5, 0, "R2 set wins over clear");
    wr('h10, 32'h20);
    expect_out(0, 0, 0, "R2 clear removes last pending");
    pulse(5);
    expect_out(1, 5, 0, "R2 flag set again");

    wr('h22, 32'h40);                               // enable source 70
    pulse(70);
    expect_out(1, 7, 0, "R4 source 70 feeds vector 7");
    wr('h12, 32'h40);
    expect_out(1, 5, 0, "R4 clear source 70");

    wr('h40 + 9, pri_word(0, 3));
    pulse(9);
    expect_out(1, 5, 0, "R5 group zero never wins");

    wr('h40 + 10, pri_word(3, 2));
    pulse(10);
    expect_out(1, 10, 0, "R6 higher sub-priority wins");
    wr('h40 + 12, pri_word(3, 2));
    pulse(12);
    expect_out(1, 10, 0, "R6 full tie keeps lower vector");
    wr('h40 + 4, pri_word(3, 2));
    pulse(4);
    expect_out(1, 4, 0, "R6 full tie lower vector takes over");

    ack();
    expect_out(0, 4, 3, "R8 acknowledge raises level");

    wr('h40 + 20, pri_word(3, 3));
    pulse(20);
    expect_out(0, 20, 3, "R7 equal group with higher sub does not preempt");
    pulse(7);
    expect_out(1, 7, 3, "R7 higher group preempts");
    ack();
    expect_out(0, 7, 6, "R8 nested acknowledge");

    ret();
    expect_out(1, 7, 3, "R9 return pops saved level");
    wr('h10, 32'h80);
    expect_out(0, 20, 3, "R7 equal group after clear");
    ret();
    expect_out(1, 20, 0, "R9 return to base level");
    ret();
    expect_out(1, 20, 0, "R9 return on empty stack");

    wr('h00, 32'h0);
    expect_out(1, 0, 0, "R10 single-vector reports vector 0");
    ack();
    expect_out(0, 0, 3, "R10 priority still applies in single mode");

    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule